// File: doc/BRIEF.md
# Queued-Update Pulse-Width Modulator

This block drives one pulse-width-modulated output. The period is fixed at sixteen clocks. A 4-bit duty code sets how many of those sixteen clocks the output spends high, so each step of the code adds one sixteenth (6.25%) of the period. The active code is double-buffered and only changes at a period boundary. A period that has started always runs to its end with the code it started with.

The control input is a plain level with no handshake. Any clock on which it differs from its value on the previous clock counts as a change, and the new value is written into an eight-entry queue. At each period rollover one queued code, if there is one, becomes the active code. A burst of control changes shorter than a period therefore still plays out one full period per requested level. The block has no back-pressure. While the queue is full a flag is raised and further changes are discarded. The source is expected to watch that flag if it cannot afford to lose levels.

Top module: `pwm_queued_top`

## Requirements
- R1: The period is 16 clocks. An internal counter restarts at phase 0 when reset is released. The clock after a period's phase 15 is phase 0 of the next period.
- R2: In a period whose active code is N, the output is high during phases 0 to N-1 and low for the rest. Code 0 gives an output that stays low. Code 15 gives 15 high clocks, so phase 15 is low in every period.
- R3: A change on the control input never alters the period in progress. The remaining phases of that period keep the code the period started with.
- R4: Every clock on which the control input differs from its previous-clock value queues the new value. At each rollover one queued code is taken, oldest first, and governs the next period.
- R5: If the queue is empty at a rollover, the active code stays as it was for the next period.
- R6: The queue holds 8 codes. The full flag is high while 8 codes are waiting. A change that arrives while the queue is full is discarded and never becomes active.
- R7: A change presented during phase 15 is queued on the rollover edge itself. It is not applied at that rollover, so the next period keeps the old code and the new code governs the period after it.
- R8: The synchronous active-low reset clears the counter, the active code, the queue, the full flag and the output. It also sets the stored previous input value to 0, so a nonzero control value held through reset is queued once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (50 MHz) |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_code_i | input | 4 | Requested duty code, number of high clocks per period |
| pwm_o | output | 1 | Registered PWM output |
| queue_full_o | output | 1 | High while the update queue holds 8 codes |

## Verification
The assertions take it as given that the control input is synchronous to the clock: it changes only between edges and is stable at each rising edge. They also assume that reset is held low for at least one edge before operation. Every input in the bench is driven from a single sequential thread on falling edges, so each value has settled half a period before the edge that samples it. The bench's phase reference follows the rising edges and is cleared by the same reset, so each change can be placed at a known phase, including the last phase of a period.

// File: rtl/pwm_queued_pkg.sv
package pwm_queued_pkg;

  localparam int CODE_W_DEF = 4;
  localparam int QDEPTH_DEF = 8;

  typedef struct packed {
    logic empty;
    logic full;
  } q_flags_t;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int lvl_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/pwm_change_detect.sv
module pwm_change_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic         change_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign change_o = (level_i != prev_q);

endmodule

// File: rtl/pwm_code_fifo.sv
module pwm_code_fifo
  import pwm_queued_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_i,
  input  logic [W-1:0]                data_i,
  input  logic                        pop_i,
  output logic [W-1:0]                data_o,
  output q_flags_t                    flags_o,
  output logic [lvl_bits(DEPTH)-1:0]  level_o
);

  localparam int AW = ptr_bits(DEPTH);
  localparam int LW = lvl_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  assign flags_o.empty = (lvl_q == '0);
  assign flags_o.full  = (lvl_q == FULL_LVL);
  assign push_ok = push_i && !flags_o.full;
  assign pop_ok  = pop_i && !flags_o.empty;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wr_q <= step(wr_q);
      if (pop_ok)  rd_q <= step(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  assign data_o  = mem[rd_q];
  assign level_o = lvl_q;

endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              avail_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pop_o,
  output logic [CODE_W-1:0] cnt_o,
  output logic [CODE_W-1:0] duty_o,
  output logic              pwm_o
);

  localparam logic [CODE_W-1:0] LAST_PH = '1;

  logic [CODE_W-1:0] cnt_q, duty_q, cnt_nxt, duty_nxt;
  logic              pwm_q, rollover;

  assign rollover = (cnt_q == LAST_PH);
  assign pop_o    = rollover && avail_i;
  assign cnt_nxt  = cnt_q + 1'b1;
  assign duty_nxt = pop_o ? code_i : duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      duty_q <= duty_nxt;
      pwm_q  <= (cnt_nxt < duty_nxt);
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign pwm_o  = pwm_q;

endmodule

// File: rtl/pwm_queued_top.sv
module pwm_queued_top
  import pwm_queued_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int QDEPTH = QDEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] duty_code_i,
  output logic              pwm_o,
  output logic              queue_full_o
);

  localparam int LW = lvl_bits(QDEPTH);

  logic              chg_w, pop_w;
  logic [CODE_W-1:0] head_w, cnt_w, duty_w;
  q_flags_t          flags_w;
  logic [LW-1:0]     level_w;

  pwm_change_detect #(.W(CODE_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (duty_code_i),
    .change_o (chg_w)
  );

  pwm_code_fifo #(.W(CODE_W), .DEPTH(QDEPTH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (chg_w),
    .data_i  (duty_code_i),
    .pop_i   (pop_w),
    .data_o  (head_w),
    .flags_o (flags_w),
    .level_o (level_w)
  );

  pwm_period_gen #(.CODE_W(CODE_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail_i (!flags_w.empty),
    .code_i  (head_w),
    .pop_o   (pop_w),
    .cnt_o   (cnt_w),
    .duty_o  (duty_w),
    .pwm_o   (pwm_o)
  );

  assign queue_full_o = flags_w.full;

endmodule

// File: rtl/pwm_queued_chk.sv
module pwm_queued_chk #(
  parameter int CODE_W = 4,
  parameter int QDEPTH = 8,
  parameter int LW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cnt_i,
  input logic [CODE_W-1:0] duty_i,
  input logic [LW-1:0]     level_i,
  input logic              full_i,
  input logic              pwm_i
);

  localparam logic [CODE_W-1:0] LAST_PH = '1;

  // R1: phase counter advances by one every clock, wrapping after 15
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_i == CODE_W'($past(cnt_i) + 1'b1));

  // R2: output high exactly while the phase is below the active code
  p_pwm_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_i == (cnt_i < duty_i));

  // R2: last phase of each period is always low
  p_last_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == LAST_PH) |-> !pwm_i);

  // R3: active code cannot move except across a rollover
  p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != LAST_PH) |=> $stable(duty_i));

  // R5: empty queue at rollover keeps the code
  p_hold_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == LAST_PH && level_i == '0) |=> $stable(duty_i));

  // R6: queue never exceeds its depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level_i <= LW'(QDEPTH));

  // R6: full stays full until a rollover can drain an entry
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_i && cnt_i != LAST_PH) |=> full_i);

endmodule

bind pwm_queued_top pwm_queued_chk #(
  .CODE_W (CODE_W),
  .QDEPTH (QDEPTH),
  .LW     (pwm_queued_pkg::lvl_bits(QDEPTH))
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_i   (cnt_w),
  .duty_i  (duty_w),
  .level_i (level_w),
  .full_i  (queue_full_o),
  .pwm_i   (pwm_o)
);

// File: tb/tb_pwm_queued_top.sv
`timescale 1ns/1ps
module tb_pwm_queued_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ctrl;
  logic       pwm, full;
  logic [3:0] ph;
  int         n_chk = 0;
  int         n_fail = 0;

  pwm_queued_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .duty_code_i  (ctrl),
    .pwm_o        (pwm),
    .queue_full_o (full)
  );

  always #10 clk = ~clk;

  // phase reference from R1
  always @(posedge clk) begin
    if (!rst_n) ph <= 4'd0;
    else        ph <= ph + 4'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ph(input int p);
    do @(negedge clk); while (ph != 4'(p));
  endtask

  // one whole period starting at phase 0, shape per R1/R2
  task automatic check_period(input int exp, input string tag);
    int got = 0;
    int bad = 0;
    wait_ph(0);
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm) got++;
      if (pwm !== (i < exp)) bad++;
    end
    chk(bad == 0, tag, got, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    ctrl  = 4'd0;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R8 output low in reset", pwm, 0);
    chk(full == 1'b0, "R8 full low in reset", full, 0);
    rst_n = 1'b1;
    check_period(0, "R2 code 0 all low / R1 period");
  endtask

  task automatic t_sweep;
    for (int code = 1; code < 16; code++) begin
      int bad = 0;
      wait_ph(5);
      if (pwm !== (5 < code - 1)) bad++;
      ctrl = 4'(code);
      for (int i = 6; i < 16; i++) begin
        @(negedge clk);
        if (pwm !== (i < code - 1)) bad++;
      end
      chk(bad == 0, "R3 period in progress unchanged", bad, 0);
      check_period(code, (code == 15) ? "R2 code 15 max" : "R2 duty sweep");
    end
  endtask

  task automatic t_queue;
    wait_ph(2); ctrl = 4'd5;
    wait_ph(4); ctrl = 4'd9;
    wait_ph(6); ctrl = 4'd12;
    check_period(5, "R4 first queued");
    check_period(9, "R4 second queued");
    check_period(12, "R4 third queued");
    check_period(12, "R5 empty holds");
    check_period(12, "R5 empty holds again");
  endtask

  task automatic t_late;
    wait_ph(15); ctrl = 4'd3;
    check_period(12, "R7 late change not applied at once");
    check_period(3, "R7 late change applied next");
  endtask

  task automatic t_full;
    wait_ph(1);
    for (int k = 1; k <= 10; k++) begin
      if (k > 1) @(negedge clk);
      ctrl = 4'(k);
    end
    wait_ph(12);
    chk(full == 1'b1, "R6 full after 8 changes", full, 1);
    check_period(1, "R6 queued 1");
    chk(full == 1'b0, "R6 full clears after pop", full, 0);
    for (int v = 2; v <= 8; v++) check_period(v, "R6 queued in order");
    check_period(8, "R6 dropped changes never applied");
  endtask

  task automatic t_reset_mid;
    int bad = 0;
    wait_ph(3); ctrl = 4'd6;
    wait_ph(4); ctrl = 4'd14;
    wait_ph(6);
    rst_n = 1'b0;
    ctrl  = 4'd7;
    repeat (2) @(negedge clk);
    chk(pwm == 1'b0 && full == 1'b0, "R8 mid reset clears outputs", {full, pwm}, 0);
    rst_n = 1'b1;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (pwm !== 1'b0) bad++;
    end
    chk(bad == 0, "R8 queue and code cleared", bad, 0);
    check_period(7, "R8 held input queued after reset");
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_queue();
    t_late();
    t_full();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule